// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block sits between an on-chip read port and an external serial flash. Each read request that enters the flash window becomes one complete serial read frame. The frame holds an opcode, the address bytes, an optional gap of idle clocks and a 32-bit data fetch. The assembled word goes back on a response channel. The frame shape comes from four configuration registers written through a plain register port. These registers set the opcode, the number of idle clocks, a lane width of one, two or four lines for each phase, the address byte count, the serial clock divider and an optional address offset.

Both the request and the response channels use valid/ready. A request is taken only when `req_valid` and `req_ready` are high on the same clock edge, and `req_ready` is high only while no frame or response is pending. After the response is raised it holds its data and error flag unchanged until `rsp_ready` accepts it, so the consumer may stall as long as it likes. While the block is disabled, a request gets an error response and no frame is started.

Top module: `xip_read_bridge`

## Requirements
- R1: The register select `cfg_sel` picks control (0), read-format (1), size (2) or offset (3). After reset these read as 0x80080080, 0x080220EB, 0x00101002 and 0x00000000. Control bit 31 always reads the live idle flag.
- R2: A frame lowers `fl_cs_n` and sends, most significant bit first, the read-format opcode (bits 7:0) and then the address bytes. It then runs the number of idle clock periods given by read-format bits 28:24 (zero skips the gap), followed by 32 data bits. The address byte count is size bits 3:0 plus one, and values above 3 are treated as four bytes.
- R3: Lane codes are 0 for one line, 1 for two and 2 for four (3 acts as one line). The instruction lane code is in read-format bits 9:8, the address code in 13:12 and the data code in 17:16. Outgoing bits use `fl_io_out[0]`, `[1:0]` or `[3:0]`, with the higher line carrying the earlier bit, and `fl_io_oe` enables exactly those lines. Single-line data is read on `fl_io_in[1]`. `fl_io_oe` is 0 during the gap, during data and while `fl_cs_n` is high.
- R4: When the instruction lane code is not 0, the address and data phases use the instruction's lane width and their own fields are ignored.
- R5: The response word places the first received byte in bits 7:0 and the fourth in bits 31:24. Each byte arrives most significant bit first.
- R6: `fl_sck` idles low and toggles every c+1 system clocks, where c is control bits 22:19. One period is therefore 2(c+1) clocks (divide ratio div gives c = div/2-1). Data is sampled on the rising edge.
- R7: When control bit 16 is set, the offset register is added to `req_addr` before the address is sent.
- R8: While control bit 0 (enable) is 1, writes to the offset register and changes to control bit 16 are ignored.
- R9: While a frame or response is pending, the idle flag reads 0 and all configuration writes are ignored.
- R10: A request accepted while enable is 0 is answered by an error response with data 0, and no frame is started.
- R11: `req_ready` is high only in idle. `rsp_valid` rises only after `fl_cs_n` has returned high. The response stays unchanged until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted |
| req_addr | input | ADDR_W | Read address within the window |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_data | output | 32 | Assembled read word |
| rsp_err | output | 1 | Request refused (block disabled) |
| fl_sck | output | 1 | Serial clock |
| fl_cs_n | output | 1 | Chip select, active low |
| fl_io_out | output | 4 | Outgoing serial lines |
| fl_io_oe | output | 4 | Per-line output enable |
| fl_io_in | input | 4 | Incoming serial lines |

## Verification
The assertions assume that the flash holds its lines steady around each rising serial clock edge. They also assume the response consumer may delay `rsp_ready` without bound, and that requests and register writes may arrive in any cycle, including during a frame. The bench's flash model changes its data lines only on falling serial clock edges. The stimulus keeps lane codes within 0 to 2, keeps divider and gap values small for most frames, and runs a few frames at the largest settings. Register writes are made both at idle and deliberately in the middle of a frame, so that the ignore rules are exercised.

// File: rtl/xipr_pkg.sv
package xipr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_GAP, ST_DATA, ST_RESP
  } xipr_state_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic [4:0] gap;
    logic [1:0] cmd_lg;
    logic [1:0] addr_lg;
    logic [1:0] data_lg;
    logic [2:0] addr_bytes;
    logic [3:0] div_code;
  } xipr_frame_t;

  // lane code -> log2 of active line count
  function automatic logic [1:0] lane_lg(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/xipr_cfg_regs.sv
module xipr_cfg_regs
  import xipr_pkg::*;
#(
  parameter logic [31:0] CTRL_RST  = 32'h0008_0080,
  parameter logic [31:0] FMT_RST   = 32'h0802_20EB,
  parameter logic [31:0] SIZE_RST  = 32'h0010_1002
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [1:0]  sel,
  input  logic [31:0] wdata,
  input  logic        idle,
  output logic [31:0] rdata,
  output xipr_frame_t frame,
  output logic        enable,
  output logic        remap_en,
  output logic [31:0] remap_off
);
  logic [30:0] ctrl_q;
  logic [31:0] fmt_q, size_q, remap_q;
  logic [1:0]  ins_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST[30:0];
      fmt_q   <= FMT_RST;
      size_q  <= SIZE_RST;
      remap_q <= '0;
    end else if (wr && idle) begin
      case (sel)
        2'd0: ctrl_q <= {wdata[30:17], (ctrl_q[0] ? ctrl_q[16] : wdata[16]), wdata[15:0]};
        2'd1: fmt_q  <= wdata;
        2'd2: size_q <= wdata;
        default: if (!ctrl_q[0]) remap_q <= wdata;
      endcase
    end
  end

  always_comb begin
    case (sel)
      2'd0:    rdata = {idle, ctrl_q};
      2'd1:    rdata = fmt_q;
      2'd2:    rdata = size_q;
      default: rdata = remap_q;
    endcase
  end

  assign ins_code         = fmt_q[9:8];
  assign frame.opcode     = fmt_q[7:0];
  assign frame.gap        = fmt_q[28:24];
  assign frame.cmd_lg     = lane_lg(ins_code);
  assign frame.addr_lg    = (ins_code != 2'd0) ? lane_lg(ins_code) : lane_lg(fmt_q[13:12]);
  assign frame.data_lg    = (ins_code != 2'd0) ? lane_lg(ins_code) : lane_lg(fmt_q[17:16]);
  assign frame.addr_bytes = (size_q[3:0] > 4'd3) ? 3'd4 : {1'b0, size_q[1:0]} + 3'd1;
  assign frame.div_code   = ctrl_q[22:19];
  assign enable    = ctrl_q[0];
  assign remap_en  = ctrl_q[16];
  assign remap_off = remap_q;

  a_r8_remap_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[0] |=> ($stable(remap_q) && $stable(ctrl_q[16])));
  a_r9_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(fmt_q) && $stable(size_q) && $stable(ctrl_q)));
endmodule

// File: rtl/xipr_clkgen.sv
module xipr_clkgen #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] div_code,
  output logic          sck,
  output logic          rise,
  output logic          fall
);
  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == div_code);
  assign rise = wrap && !sck;
  assign fall = wrap && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r6_sck_parked: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck);
endmodule

// File: rtl/xipr_seq.sv
module xipr_seq
  import xipr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_err,
  input  logic              enable,
  input  logic              remap_en,
  input  logic [31:0]       remap_off,
  input  xipr_frame_t       frame,
  input  logic              rise,
  input  logic              fall,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              cs_n,
  output logic              run,
  output logic              idle,
  output logic [3:0]        div_code
);
  localparam int PW = 6;

  xipr_state_e  state;
  xipr_frame_t  fq;
  logic [31:0]  tx, rx, addr_q, eff_addr;
  logic [PW-1:0] left;
  logic         err_q;
  logic [1:0]   cur_lg;

  assign eff_addr = 32'(req_addr) + (remap_en ? remap_off : 32'd0);

  always_comb begin
    case (state)
      ST_CMD:  cur_lg = fq.cmd_lg;
      ST_ADDR: cur_lg = fq.addr_lg;
      ST_DATA: cur_lg = fq.data_lg;
      default: cur_lg = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      fq     <= '0;
      tx     <= '0;
      rx     <= '0;
      addr_q <= '0;
      left   <= '0;
      err_q  <= 1'b0;
      cs_n   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          if (!enable) begin
            err_q <= 1'b1;
            rx    <= '0;
            state <= ST_RESP;
          end else begin
            err_q  <= 1'b0;
            fq     <= frame;
            addr_q <= eff_addr;
            tx     <= {frame.opcode, 24'd0};
            left   <= PW'(6'd8 >> frame.cmd_lg);
            cs_n   <= 1'b0;
            state  <= ST_CMD;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: begin
          if (rise && state == ST_DATA) begin
            case (fq.data_lg)
              2'd1:    rx <= {rx[29:0], io_in[1:0]};
              2'd2:    rx <= {rx[27:0], io_in};
              default: rx <= {rx[30:0], io_in[1]};
            endcase
          end
          if (fall) begin
            if (left != PW'(1)) begin
              left <= left - 1'b1;
              case (cur_lg)
                2'd1:    tx <= tx << 2;
                2'd2:    tx <= tx << 4;
                default: tx <= tx << 1;
              endcase
            end else begin
              case (state)
                ST_CMD: begin
                  tx    <= addr_q << (6'd8 * (6'd4 - 6'(fq.addr_bytes)));
                  left  <= PW'((6'(fq.addr_bytes) << 3) >> fq.addr_lg);
                  state <= ST_ADDR;
                end
                ST_ADDR: if (fq.gap != 5'd0) begin
                  left  <= PW'(fq.gap);
                  state <= ST_GAP;
                end else begin
                  left  <= PW'(6'd32 >> fq.data_lg);
                  state <= ST_DATA;
                end
                ST_GAP: begin
                  left  <= PW'(6'd32 >> fq.data_lg);
                  state <= ST_DATA;
                end
                default: begin
                  cs_n  <= 1'b1;
                  state <= ST_RESP;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    io_out = 4'd0;
    io_oe  = 4'd0;
    if (state == ST_CMD || state == ST_ADDR) begin
      case (cur_lg)
        2'd1:    begin io_out = {2'b00, tx[31:30]}; io_oe = 4'b0011; end
        2'd2:    begin io_out = tx[31:28];          io_oe = 4'b1111; end
        default: begin io_out = {3'b000, tx[31]};   io_oe = 4'b0001; end
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign idle      = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_err   = err_q;
  assign rsp_data  = {rx[7:0], rx[15:8], rx[23:16], rx[31:24]};
  assign run       = !(state == ST_IDLE || state == ST_RESP);
  assign div_code  = fq.div_code;

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
  a_r11_ready_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);
  a_r3_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'd0));
  a_r10_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !enable) |=> (cs_n && rsp_valid && rsp_err));
endmodule

// File: rtl/xip_read_bridge.sv
module xip_read_bridge
  import xipr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_err,
  output logic              fl_sck,
  output logic              fl_cs_n,
  output logic [3:0]        fl_io_out,
  output logic [3:0]        fl_io_oe,
  input  logic [3:0]        fl_io_in
);
  xipr_frame_t frame;
  logic        enable, remap_en, idle, run, rise, fall;
  logic [31:0] remap_off;
  logic [3:0]  div_code;

  xipr_cfg_regs u_regs (
    .clk, .rst_n, .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata), .idle,
    .rdata(cfg_rdata), .frame, .enable, .remap_en, .remap_off
  );

  xipr_clkgen #(.CW(4)) u_clk (
    .clk, .rst_n, .run, .div_code, .sck(fl_sck), .rise, .fall
  );

  xipr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .rsp_valid, .rsp_ready,
    .rsp_data, .rsp_err, .enable, .remap_en, .remap_off, .frame, .rise, .fall,
    .io_in(fl_io_in), .io_out(fl_io_out), .io_oe(fl_io_oe), .cs_n(fl_cs_n),
    .run, .idle, .div_code
  );
endmodule

// File: tb/xip_read_bridge_tb.sv
module xip_read_bridge_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req_valid = 1'b0, req_ready, rsp_valid, rsp_ready = 1'b0, rsp_err;
  logic [31:0] req_addr = '0, rsp_data;
  logic        fl_sck, fl_cs_n;
  logic [3:0]  fl_io_out, fl_io_oe, fl_io_in = 4'd0;

  int n_chk = 0, n_bad = 0, cs_falls = 0;
  logic [31:0] c_fmt = 32'h0802_20EB, c_size = 32'h0010_1002, c_remap = 0;
  logic [31:0] c_ctrl = 32'h0008_0080;

  always #2.5 clk = ~clk;

  xip_read_bridge u_dut (.*);

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int lgof(input logic [1:0] c);
    return (c == 2'd1) ? 1 : (c == 2'd2) ? 2 : 0;
  endfunction
  function automatic int clg(); return lgof(c_fmt[9:8]); endfunction
  function automatic int alg(); return (c_fmt[9:8] != 0) ? clg() : lgof(c_fmt[13:12]); endfunction
  function automatic int dlg(); return (c_fmt[9:8] != 0) ? clg() : lgof(c_fmt[17:16]); endfunction
  function automatic int nbytes(); return (c_size[3:0] > 3) ? 4 : int'(c_size[1:0]) + 1; endfunction
  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'hC3;
  endfunction
  function automatic logic [31:0] exp_addr(input logic [31:0] ra);
    logic [31:0] a = ra + (c_ctrl[16] ? c_remap : 32'd0);
    return (nbytes() == 4) ? a : (a & ((32'd1 << (8 * nbytes())) - 1));
  endfunction

  // flash model
  int k, cmdP, addrP, dstart, dataP;
  logic [31:0] rx_op, rx_addr, s_word;
  int oe_bad;
  realtime t0, t1;

  always @(negedge fl_cs_n) begin
    cs_falls++;
    k = 0; rx_op = 0; rx_addr = 0; oe_bad = 0;
    cmdP = 8 >> clg(); addrP = (nbytes() * 8) >> alg();
    dstart = cmdP + addrP + int'(c_fmt[28:24]); dataP = 32 >> dlg();
  end

  always @(posedge fl_sck) if (!fl_cs_n) begin
    int w; logic [3:0] m;
    if (k == 0) t0 = $realtime;
    if (k == 1) t1 = $realtime;
    if (k < cmdP + addrP) begin
      w = 1 << ((k < cmdP) ? clg() : alg());
      m = 4'((1 << w) - 1);
      if (fl_io_oe !== m) oe_bad++;
      if (k < cmdP) rx_op = (rx_op << w) | 32'(fl_io_out & m);
      else          rx_addr = (rx_addr << w) | 32'(fl_io_out & m);
    end else if (fl_io_oe !== 4'd0) oe_bad++;
    k++;
  end

  always @(negedge fl_sck) if (!fl_cs_n && k >= dstart && k < dstart + dataP) begin
    int w, j; logic [31:0] b;
    if (k == dstart)
      s_word = {mem_byte(rx_addr), mem_byte(rx_addr + 1), mem_byte(rx_addr + 2), mem_byte(rx_addr + 3)};
    w = 1 << dlg(); j = k - dstart;
    b = (s_word >> (32 - (j + 1) * w)) & ((32'd1 << w) - 1);
    fl_io_in = (w == 1) ? {2'b00, b[0], 1'b0} : b[3:0];
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask
  task automatic cfg_read(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); cfg_sel = sel; #0.5; d = cfg_rdata;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d, output logic e);
    int hold;
    @(negedge clk); req_addr = a; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data; e = rsp_err;
    check("R11 cs released before response", 32'(fl_cs_n), 32'd1);
    hold = $urandom_range(0, 3);
    repeat (hold) begin
      @(negedge clk);
      check("R11 response held", {rsp_data[31:1], rsp_valid}, {d[31:1], 1'b1});
    end
    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
  endtask

  task automatic setup(input logic [31:0] fmt, input logic [31:0] sz, input logic [3:0] dc,
                       input logic rmen, input logic [31:0] rm);
    logic [31:0] ctl;
    ctl = {9'd0, dc, 2'b01, rmen, 8'h00, 8'h80};   // bits 22:19, 16, 7
    cfg_write(2'd0, ctl & ~32'd1);
    cfg_write(2'd3, rm);
    cfg_write(2'd1, fmt);
    cfg_write(2'd2, sz);
    cfg_write(2'd0, ctl | 32'd1);
    c_fmt = fmt; c_size = sz; c_remap = rm; c_ctrl = ctl | 32'd1;
  endtask

  task automatic frame_check(input logic [31:0] ra, input string tag);
    logic [31:0] d, ea; logic e;
    ea = exp_addr(ra);
    do_read(ra, d, e);
    check({tag, " R10 no error when enabled"}, 32'(e), 32'd0);
    check({tag, " R2 opcode"}, rx_op, 32'(c_fmt[7:0]));
    check({tag, " R2 R7 address"}, rx_addr, ea);
    check({tag, " R3 R4 lane enables"}, 32'(oe_bad), 32'd0);
    check({tag, " R5 word"}, d, {mem_byte(ea + 3), mem_byte(ea + 2), mem_byte(ea + 1), mem_byte(ea)});
    check({tag, " R6 sck period"}, 32'(int'((t1 - t0) * 10.0)), 32'((int'(c_ctrl[22:19]) + 1) * 100));
  endtask

  task automatic run_all();
    logic [31:0] v, d; logic e; int f0;
    repeat (4) @(negedge clk); rst_n = 1'b1;
    // R1 reset values
    cfg_read(2'd0, v); check("R1 control reset", v, 32'h8008_0080);
    cfg_read(2'd1, v); check("R1 format reset", v, 32'h0802_20EB);
    cfg_read(2'd2, v); check("R1 size reset", v, 32'h0010_1002);
    cfg_read(2'd3, v); check("R1 offset reset", v, 32'h0);
    // R10 refused while disabled
    f0 = cs_falls;
    do_read(32'h1234, d, e);
    check("R10 error flag", 32'(e), 32'd1);
    check("R10 error data", d, 32'd0);
    check("R10 no frame", 32'(cs_falls), 32'(f0));
    // reset format, enabled, default divider
    cfg_write(2'd0, 32'h0008_0081); c_ctrl = 32'h0008_0081;
    frame_check(32'h00AB_CDEF, "default");
    // R8 offset locked while enabled
    cfg_write(2'd3, 32'h5555_0000);
    cfg_read(2'd3, v); check("R8 offset write ignored", v, 32'h0);
    cfg_write(2'd0, 32'h0009_0081);
    cfg_read(2'd0, v); check("R8 remap enable locked", 32'(v[16]), 32'd0);
    // R4 quad instruction overrides address/data fields, R7 remap
    setup(32'h0300_0235, 32'h3, 4'd0, 1'b1, 32'h0100_0010);
    frame_check(32'h0000_0F00, "R4 quad override");
    // R2 four-byte cap with size code 15, long gap, slowest divider
    setup(32'h1F01_1003, 32'hF, 4'd15, 1'b0, 32'h0);
    frame_check(32'hDEAD_BEEF, "R2 max");
    // R9 writes ignored mid-frame, idle flag low
    setup(32'h0002_1013, 32'h1, 4'd2, 1'b0, 32'h0);
    fork
      frame_check(32'h0000_0042, "R9 busy");
      begin
        repeat (8) @(negedge clk);
        #0.5; cfg_sel = 2'd0; #0.5;
        check("R9 idle flag low", 32'(cfg_rdata[31]), 32'd0);
        cfg_write(2'd1, 32'h0000_00FF);
      end
    join
    cfg_read(2'd1, v); check("R9 format unchanged", v, 32'h0002_1013);
    // random frames
    for (int i = 0; i < 30; i++) begin
      logic [31:0] fmt; logic [1:0] im;
      im  = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 2)) : 2'd0;
      fmt = {3'd0, 5'($urandom_range(0, 12)), 6'd0, 2'($urandom_range(0, 2)),
             2'd0, 2'($urandom_range(0, 2)), 2'd0, im, 8'($urandom)};
      setup(fmt, 32'($urandom_range(0, 5)), 4'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), $urandom);
      frame_check($urandom, "random");
    end
  endtask

  initial begin
    bit timeout = 0;
    void'($urandom(32'd7341));
    fork
      run_all();
      begin #(200000 * 5ns); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule